// File: doc/BRIEF.md
# Write-Side Space Flag for a Two-Clock FIFO

This block produces the write-side status flag of a FIFO whose write and read ports run on unrelated clocks. It holds the write and read pointers. It moves the read pointer into the write-clock domain as a Gray code, so a sample taken while the pointer is changing is never torn. It also gates the caller's write strobe so that no word is accepted while the queue has no free slot. The storage array, the output register and any almost-full threshold belong to neighbouring logic. That logic uses `wr_fire` and `wr_addr` as its write enable and write address, and `rd_addr` as its read address.

The flag is registered in the write domain and is high whenever the write side knows of at least one free slot. A mode input selects how the flag is read. With `fwft_mode` low it is an active-low "full" indication. With `fwft_mode` high it is an active-high "input ready" indication. The level is the same in both cases. A read frees its slot for the writer only after two write-clock rising edges: the first edge samples the read pointer and the second loads the flag. The depth is `2**ADDR_W` with `ADDR_W >= 2`. Each pointer carries one extra wrap bit.

Top module: `wfifo_space_flag`

## Requirements
- R1: `wflag` is 1 when the write side sees fewer than DEPTH unread words and 0 when it sees exactly DEPTH. The count never exceeds DEPTH, and after the queue is drained the flag is 1.
- R2: A write request (`wr_en`=1) while `wflag` is 0 is ignored: `wr_fire` stays 0 and `wr_addr` keeps its value.
- R3: `wr_fire` equals `wr_en` AND `wflag` in the same cycle. Each accepted write advances `wr_addr` by one, modulo DEPTH, at that write-clock edge.
- R4: A write that fills the last free slot drives `wflag` to 0 at the same write-clock edge that accepts the write.
- R5: After a read frees the slot the writer needs next, `wflag` is still 0 after the first write-clock rising edge that follows the read. It is 1 after the second.
- R6: `fwft_mode` has no effect on the level of `wflag`. 0 selects the active-low full meaning and 1 selects the active-high ready meaning.
- R7: While `rst_n` is 0, `wflag` is 0 and both addresses are 0. After release, `wflag` is still 0 following the first and second write-clock rising edges and is 1 following the third.
- R8: Each cycle of `rd_en`=1 advances `rd_addr` by one, modulo DEPTH, at that read-clock edge. The caller asserts `rd_en` only when the queue holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode | input | 1 | Flag meaning select: 0 = full (active low), 1 = input ready (active high) |
| wr_en | input | 1 | Write request, sampled on wclk |
| rd_en | input | 1 | Read strobe, sampled on rclk |
| wflag | output | 1 | Space flag, 1 = at least one slot free |
| wr_fire | output | 1 | Accepted write, for the storage write enable |
| wr_addr | output | ADDR_W | Write slot address |
| rd_addr | output | ADDR_W | Read slot address |

## Verification
The hardest case to reach from the ports is a queue that is exactly full when one read lands between two write-clock edges. Only that case shows that the flag waits a full second write edge before it rises. The bench holds reads off and writes until the flag drops. It then issues one read and counts write-clock edges from the moment the read is taken. The two clocks have periods whose edges never coincide, so the first write edge after the read is unambiguous. A long mixed phase then alternates write-heavy and read-heavy bursts, with mode flips, so that the queue repeatedly hits full and wraps both pointers. A reference model compares the outputs against a per-cycle count of words and reads.

// File: rtl/wsf_pkg.sv
`timescale 1ns/1ps
package wsf_pkg;
  // Meaning attached to the shared flag output.
  typedef enum logic {
    MODE_FULL_N = 1'b0,
    MODE_READY  = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/wsf_rst_sync.sv
`timescale 1ns/1ps
module wsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wsf_gray_ctr.sv
`timescale 1ns/1ps
module wsf_gray_ctr #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q,
  output logic [PW-1:0] gray_nxt
);
  logic [PW-1:0] bin_nxt;

  always_comb begin
    bin_nxt  = bin_q + PW'(inc);
    gray_nxt = bin_nxt ^ (bin_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc) begin
      bin_q  <= bin_nxt;
      gray_q <= gray_nxt;
    end
  end

  // The value crossing domains may change in one bit at most per clock (R5).
  p_gray_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/wsf_space_ctl.sv
`timescale 1ns/1ps
module wsf_space_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic            wclk,
  input  logic            wrst_n,
  input  logic            wr_en,
  input  logic [ADDR_W:0] w_bin,
  input  logic [ADDR_W:0] w_gray_nxt,
  input  logic [ADDR_W:0] r_gray_async,
  output logic            space_q,
  output logic            wr_fire
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] r_gray_s1;
  logic [PW-1:0] full_pat;
  logic [PW-1:0] r_bin_s1;
  logic          space_d;

  // Full when the next write pointer equals the sampled read pointer with
  // its two top Gray bits inverted (one full lap ahead).
  always_comb begin
    full_pat = {~r_gray_s1[PW-1:PW-2], r_gray_s1[PW-3:0]};
    space_d  = (w_gray_nxt != full_pat);
  end

  // First sample stage of the read pointer; the flag flop is the second.
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      r_gray_s1 <= '0;
      space_q   <= 1'b0;
    end else begin
      r_gray_s1 <= r_gray_async;
      space_q   <= space_d;
    end
  end

  assign wr_fire = wr_en & space_q;

  // Binary view of the sampled read pointer, used by the check below.
  always_comb begin
    r_bin_s1[PW-1] = r_gray_s1[PW-1];
    for (int i = PW - 2; i >= 0; i--) r_bin_s1[i] = r_bin_s1[i+1] ^ r_gray_s1[i];
  end

  p_no_overflow_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_bin - r_bin_s1) <= PW'(DEPTH));

  always @(posedge wclk) begin
    if (!wrst_n) begin
      p_reset_low_r7: assert (!space_q);
    end
  end
endmodule

// File: rtl/wfifo_space_flag.sv
`timescale 1ns/1ps
module wfifo_space_flag
  import wsf_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wflag,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int PW = ADDR_W + 1;

  logic          w_rst_n, r_rst_n;
  logic [PW-1:0] w_bin, w_gray, w_gray_nxt;
  logic [PW-1:0] r_bin, r_gray, r_gray_nxt;
  logic          space_q;
  logic          full_n, in_ready;
  flag_mode_e    mode_sel;

  wsf_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .arst_n(rst_n), .srst_n(w_rst_n));
  wsf_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .arst_n(rst_n), .srst_n(r_rst_n));

  wsf_gray_ctr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst_n(w_rst_n), .inc(wr_fire),
    .bin_q(w_bin), .gray_q(w_gray), .gray_nxt(w_gray_nxt));

  wsf_gray_ctr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst_n(r_rst_n), .inc(rd_en),
    .bin_q(r_bin), .gray_q(r_gray), .gray_nxt(r_gray_nxt));

  wsf_space_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .wclk(wclk), .wrst_n(w_rst_n), .wr_en(wr_en),
    .w_bin(w_bin), .w_gray_nxt(w_gray_nxt), .r_gray_async(r_gray),
    .space_q(space_q), .wr_fire(wr_fire));

  // Both meanings share one level: "not full" and "ready" coincide.
  always_comb begin
    full_n   = space_q;
    in_ready = space_q;
    mode_sel = flag_mode_e'(fwft_mode);
    case (mode_sel)
      MODE_READY: wflag = in_ready;
      default:    wflag = full_n;
    endcase
  end

  assign wr_addr = w_bin[ADDR_W-1:0];
  assign rd_addr = r_bin[ADDR_W-1:0];

  p_hold_when_low_r2: assert property (@(posedge wclk) disable iff (!w_rst_n)
    !wflag |=> $stable(w_bin));

  p_write_step_r3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wr_fire |=> (w_bin == $past(w_bin) + PW'(1)));

  p_read_step_r8: assert property (@(posedge rclk) disable iff (!r_rst_n)
    rd_en |=> (r_gray == $past(r_gray_nxt)) && (r_bin == $past(r_bin) + PW'(1)));

  p_gray_track_r3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    w_gray == (w_bin ^ (w_bin >> 1)));
endmodule

// File: tb/tb_wfifo_space_flag.sv
`timescale 1ns/1ps
module tb_wfifo_space_flag;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic rst_n, fwft_mode, wr_en, rd_en;
  logic wflag, wr_fire;
  logic [AW-1:0] wr_addr, rd_addr;

  always #2.5 wclk = ~wclk;
  always #3.6 rclk = ~rclk;

  wfifo_space_flag #(.ADDR_W(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .rd_en(rd_en), .wflag(wflag), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .rd_addr(rd_addr));

  int n_tests = 0;
  int n_fail  = 0;
  int wcount = 0, rcount = 0, rc_prev = 0, rel_edges = 0;
  bit m_flag = 1'b0;
  bit acc;
  bit run_check = 1'b0;
  int rd_mode = 0;
  int rd_pct = 0;
  bit rd_req = 1'b0;
  bit rd_done = 1'b0;

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of the write side: words written vs. reads seen one edge late.
  always @(posedge wclk) begin
    if (!rst_n) begin
      rel_edges = 0; m_flag = 1'b0; wcount = 0; rc_prev = 0;
    end else begin
      if (rel_edges < 3) rel_edges++;
      if (rel_edges >= 3) begin
        acc    = wr_en && m_flag;
        wcount = wcount + int'(acc);
        m_flag = ((wcount - rc_prev) < DEPTH);
      end
      rc_prev = rcount;
    end
  end

  always @(negedge wclk) begin
    if (run_check) begin
      chk(int'(wflag), int'(m_flag), "R1 R4 R5 R6 flag");
      chk(int'(wr_addr), wcount % DEPTH, "R3 wr_addr");
      chk(int'(wr_fire), int'(wr_en && m_flag), "R2 R3 wr_fire");
    end
  end

  always @(posedge rclk) begin
    if (rst_n && rd_en) begin
      rcount++;
      if (rd_mode == 2) begin rd_done = 1'b1; rd_req = 1'b0; end
    end
  end

  always @(negedge rclk) begin
    if (run_check) chk(int'(rd_addr), rcount % DEPTH, "R8 rd_addr");
    #1;
    case (rd_mode)
      1:       rd_en = ($urandom_range(0, 99) < rd_pct) && (wcount > rcount);
      2:       rd_en = rd_req && (wcount > rcount);
      default: rd_en = 1'b0;
    endcase
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1; fwft_mode = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge wclk);
    #1;
    chk(int'(wflag), 0, "R7 flag in reset");
    chk(int'(wr_addr), 0, "R7 wr_addr in reset");
    chk(int'(rd_addr), 0, "R7 rd_addr in reset");

    @(negedge wclk); #1 rst_n = 1'b1; run_check = 1'b1;
    @(negedge wclk); chk(int'(wflag), 0, "R7 after first edge");
    @(negedge wclk); chk(int'(wflag), 0, "R7 after second edge");
    @(negedge wclk); chk(int'(wflag), 1, "R7 after third edge");

    // Fill with no reads; extra write requests must be ignored.
    repeat (DEPTH + 6) begin @(negedge wclk); #1 wr_en = 1'b1; end
    @(negedge wclk);
    chk(int'(wflag), 0, "R2 flag low when full");
    chk(int'(wr_fire), 0, "R2 write gated");
    chk(int'(wr_addr), 0, "R2 wr_addr held after wrap");
    #1 fwft_mode = 1'b1;
    @(negedge wclk);
    chk(int'(wflag), 0, "R6 flag level in ready mode");
    #1 wr_en = 1'b0;

    // One read from a full queue: flag rises on the second write edge.
    rd_mode = 2; rd_req = 1'b1;
    wait (rd_done);
    @(posedge wclk);
    @(negedge wclk); chk(int'(wflag), 0, "R5 still low after first edge");
    @(negedge wclk); chk(int'(wflag), 1, "R5 high after second edge");
    rd_mode = 0;

    // Refill the single slot: flag drops at the accepting edge.
    #1 wr_en = 1'b1;
    @(negedge wclk); chk(int'(wflag), 0, "R4 low after last slot filled");
    #1 wr_en = 1'b0;

    // Mixed traffic with mode flips and alternating pressure.
    rd_mode = 1;
    for (int ph = 0; ph < 10; ph++) begin
      int wr_pct;
      wr_pct    = (ph % 2 == 0) ? 90 : 30;
      rd_pct    = (ph % 2 == 0) ? 30 : 90;
      fwft_mode = ph[0];
      repeat (250) begin
        @(negedge wclk); #1 wr_en = ($urandom_range(0, 99) < wr_pct);
      end
    end

    // Drain.
    @(negedge wclk); #1 wr_en = 1'b0; rd_pct = 100;
    while (rcount != wcount) @(negedge wclk);
    repeat (4) @(negedge wclk);
    chk(int'(wflag), 1, "R1 flag high when drained");
    chk(int'(rd_addr), int'(wr_addr), "R8 addresses meet when drained");

    run_check = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule